// File: doc/BRIEF.md
# Relative Branch and Loop Sequencer

This block resolves the control-flow result of an 8-bit processor's relative-jump family in a single evaluation. The caller presents the opcode byte, the signed displacement byte and the program counter value that addresses that displacement byte, along with the zero flag, the carry flag and the current B register. The block returns the next program counter, the value to write back into B together with its write enable, whether the branch was taken, and the instruction's cost in T-states.

It handles three kinds of instruction. The first is the unconditional relative jump. The second is four conditional jumps, each testing the zero flag or the carry flag for a set or clear state. The third is a loop instruction that counts B down and branches while the result is nonzero. Every other opcode is flagged invalid and leaves the program counter and B as they were. By default the results pass through one register stage that carries a valid strobe. A parameter removes that stage, which makes the block purely combinational.

Top module: `rel_branch_seq`

## Requirements
- R1: While reset is asserted, out_valid, invalid, taken, b_we, pc_next, b_next and tstates are all zero.
- R2: With the default registered stage, out_valid is high in the cycle after a cycle with in_valid high and low in the cycle after a cycle with in_valid low, and the outputs then reflect the inputs of that earlier cycle.
- R3: Opcode 0x18 always branches. pc_next is pc_in + sext(disp) + 1, taken is 1, b_we is 0, b_next equals reg_b and tstates is 12.
- R4: Opcodes 0x20, 0x28, 0x30 and 0x38 branch when Z is 0, Z is 1, C is 0 and C is 1 respectively. Opcode bit 4 picks the flag (0 selects Z, 1 selects C) and bit 3 gives the flag value that causes the branch.
- R5: A conditional jump that is taken gives pc_in + sext(disp) + 1 and costs 12 T-states. One that is not taken gives pc_in + 1 and costs 7. In both cases b_we is 0 and b_next equals reg_b.
- R6: Opcode 0x10 sets b_we to 1 and b_next to (reg_b - 1) mod 256, so reg_b = 0 gives b_next = 0xFF.
- R7: Opcode 0x10 branches to pc_in + sext(disp) + 1 and costs 13 when b_next is nonzero. When b_next is zero it gives pc_in + 1, taken is 0 and the cost is 8.
- R8: disp is a two's-complement value from -128 to +127, and every program-counter sum wraps modulo 65536.
- R9: Any opcode outside {0x10, 0x18, 0x20, 0x28, 0x30, 0x38} sets invalid to 1 and gives pc_next = pc_in, b_next = reg_b, b_we = 0, taken = 0 and tstates = 0. For the listed opcodes invalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Signed displacement byte |
| pc_in | input | 16 | Program counter addressing the displacement byte |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| reg_b | input | 8 | Current B register (loop counter) |
| out_valid | output | 1 | Outputs hold a resolved instruction |
| invalid | output | 1 | Opcode is not in the relative-jump group |
| taken | output | 1 | Branch target was selected |
| pc_next | output | 16 | Next program counter |
| b_next | output | 8 | Value for B |
| b_we | output | 1 | Write enable for B |
| tstates | output | 4 | Instruction cost in T-states |

## Verification
The bench targets the loop counter at its edges. With B = 1 the loop must exit, because a design that tested the old B instead of the decremented one would branch. With B = 0 the count must wrap to 0xFF and branch, so a design with a saturating or zero-detecting decrement would exit the loop instead. It also checks displacements of 0x80 and 0x7F close to address 0 and address 0xFFFF. A zero-extended displacement or a missing +1 would put the target exactly 256 or 1 away from the expected value. Each condition code is tried with its flag both set and clear, which catches a swapped flag or polarity. Neighbouring opcodes such as 0x08 and 0x19 must come back invalid with PC and B left untouched.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam logic [7:0] OPC_LOOP = 8'h10;
   localparam logic [7:0] OPC_JR   = 8'h18;

   typedef enum logic [1:0] {
      K_NONE   = 2'd0,
      K_LOOP   = 2'd1,
      K_ALWAYS = 2'd2,
      K_COND   = 2'd3
   } jkind_t;
endpackage

// File: rtl/rbs_decode.sv
module rbs_decode
   import rbs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [7:0]        opcode,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic [DATA_W-1:0] b_in,
   output jkind_t            kind,
   output logic [DATA_W-1:0] b_dec,
   output logic              want_branch
);
   logic cc_flag;

   always_comb begin
      kind        = K_NONE;
      b_dec       = b_in;
      want_branch = 1'b0;
      cc_flag     = opcode[4] ? flag_c : flag_z;
      case (opcode)
         OPC_LOOP: begin
            kind        = K_LOOP;
            b_dec       = b_in - DATA_W'(1);
            want_branch = |b_dec;
         end
         OPC_JR: begin
            kind        = K_ALWAYS;
            want_branch = 1'b1;
         end
         default: begin
            if (opcode[7:5] == 3'b001 && opcode[2:0] == 3'b000) begin
               kind        = K_COND;
               want_branch = (cc_flag == opcode[3]);
            end
         end
      endcase
   end
endmodule

// File: rtl/rbs_target.sv
module rbs_target #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8
) (
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] pc_skip,
   output logic [ADDR_W-1:0] pc_jump
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (EXT_W > 0) begin : g_extend
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_same
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   assign pc_skip = pc_in + ADDR_W'(1);
   assign pc_jump = pc_skip + disp_ext;
endmodule

// File: rtl/rbs_cost.sv
module rbs_cost
   import rbs_pkg::*;
#(
   parameter int TS_W         = 4,
   parameter int T_JR         = 12,
   parameter int T_JCC_TAKEN  = 12,
   parameter int T_JCC_SKIP   = 7,
   parameter int T_LOOP_TAKEN = 13,
   parameter int T_LOOP_EXIT  = 8
) (
   input  jkind_t          kind,
   input  logic            taken,
   output logic [TS_W-1:0] tstates
);
   always_comb begin
      case (kind)
         K_LOOP:   tstates = taken ? TS_W'(T_LOOP_TAKEN) : TS_W'(T_LOOP_EXIT);
         K_ALWAYS: tstates = TS_W'(T_JR);
         K_COND:   tstates = taken ? TS_W'(T_JCC_TAKEN) : TS_W'(T_JCC_SKIP);
         default:  tstates = '0;
      endcase
   end
endmodule

// File: rtl/rel_branch_seq.sv
module rel_branch_seq
   import rbs_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int TS_W         = 4,
   parameter bit REG_OUT      = 1'b1,
   parameter int T_JR         = 12,
   parameter int T_JCC_TAKEN  = 12,
   parameter int T_JCC_SKIP   = 7,
   parameter int T_LOOP_TAKEN = 13,
   parameter int T_LOOP_EXIT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] disp,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic [DATA_W-1:0] reg_b,
   output logic              out_valid,
   output logic              invalid,
   output logic              taken,
   output logic [ADDR_W-1:0] pc_next,
   output logic [DATA_W-1:0] b_next,
   output logic              b_we,
   output logic [TS_W-1:0]   tstates
);
   localparam int TS_MAX = (1 << TS_W) - 1;
   localparam int T_PEAK = (T_LOOP_TAKEN > T_JR) ? T_LOOP_TAKEN : T_JR;

   generate
      if (ADDR_W < DATA_W) begin : g_bad_addr
         $error("rel_branch_seq: ADDR_W must be at least DATA_W");
      end
      if (T_PEAK > TS_MAX || T_JCC_TAKEN > TS_MAX) begin : g_bad_cost
         $error("rel_branch_seq: T-state costs exceed TS_W");
      end
   endgenerate

   jkind_t            kind;
   logic [DATA_W-1:0] b_dec;
   logic              want;
   logic [ADDR_W-1:0] pc_skip, pc_jump;
   logic [TS_W-1:0]   c_ts;
   logic [ADDR_W-1:0] c_pc;
   logic [DATA_W-1:0] c_b;
   logic              c_we, c_inv;

   rbs_decode #(.DATA_W(DATA_W)) u_decode (
      .opcode      (opcode),
      .flag_z      (flag_z),
      .flag_c      (flag_c),
      .b_in        (reg_b),
      .kind        (kind),
      .b_dec       (b_dec),
      .want_branch (want)
   );

   rbs_target #(.ADDR_W(ADDR_W), .DISP_W(DATA_W)) u_target (
      .pc_in   (pc_in),
      .disp    (disp),
      .pc_skip (pc_skip),
      .pc_jump (pc_jump)
   );

   rbs_cost #(
      .TS_W(TS_W), .T_JR(T_JR), .T_JCC_TAKEN(T_JCC_TAKEN), .T_JCC_SKIP(T_JCC_SKIP),
      .T_LOOP_TAKEN(T_LOOP_TAKEN), .T_LOOP_EXIT(T_LOOP_EXIT)
   ) u_cost (
      .kind    (kind),
      .taken   (want),
      .tstates (c_ts)
   );

   always_comb begin
      c_inv = (kind == K_NONE);
      c_we  = (kind == K_LOOP);
      c_b   = c_we ? b_dec : reg_b;
      if (c_inv)     c_pc = pc_in;
      else if (want) c_pc = pc_jump;
      else           c_pc = pc_skip;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               invalid   <= 1'b0;
               taken     <= 1'b0;
               pc_next   <= '0;
               b_next    <= '0;
               b_we      <= 1'b0;
               tstates   <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  invalid <= c_inv;
                  taken   <= want;
                  pc_next <= c_pc;
                  b_next  <= c_b;
                  b_we    <= c_we;
                  tstates <= c_ts;
               end
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk;
         assign out_valid  = in_valid & rst_n;
         assign invalid    = rst_n & c_inv;
         assign taken      = rst_n & want;
         assign pc_next    = rst_n ? c_pc : '0;
         assign b_next     = rst_n ? c_b : '0;
         assign b_we       = rst_n & c_we;
         assign tstates    = rst_n ? c_ts : '0;
      end
   endgenerate
endmodule

// File: rtl/rel_branch_seq_chk.sv
module rel_branch_seq_chk #(
   parameter int DATA_W       = 8,
   parameter int TS_W         = 4,
   parameter bit REG_OUT      = 1'b1,
   parameter int T_JCC_SKIP   = 7,
   parameter int T_LOOP_TAKEN = 13,
   parameter int T_LOOP_EXIT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic              invalid,
   input logic              taken,
   input logic [DATA_W-1:0] b_next,
   input logic              b_we,
   input logic [TS_W-1:0]   tstates
);
   generate
      if (REG_OUT) begin : g_lat
         AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
         AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
      end
   endgenerate

   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && invalid) |-> (!taken && !b_we && tstates == '0)); // R9
   AST_LOOP_COST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && b_we) |-> (tstates == (taken ? TS_W'(T_LOOP_TAKEN) : TS_W'(T_LOOP_EXIT)))); // R7
   AST_LOOP_EXIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && b_we && !taken) |-> (b_next == '0)); // R7
   AST_SKIP_COST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !invalid && !taken && !b_we) |-> (tstates == TS_W'(T_JCC_SKIP))); // R5
   AST_TAKEN_VALID_OP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && taken) |-> !invalid); // R9
endmodule

bind rel_branch_seq rel_branch_seq_chk #(
   .DATA_W(DATA_W), .TS_W(TS_W), .REG_OUT(REG_OUT), .T_JCC_SKIP(T_JCC_SKIP),
   .T_LOOP_TAKEN(T_LOOP_TAKEN), .T_LOOP_EXIT(T_LOOP_EXIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .invalid(invalid), .taken(taken), .b_next(b_next), .b_we(b_we), .tstates(tstates)
);

// File: tb/rel_branch_seq_test.sv
module rel_branch_seq_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = '0;
   logic [7:0]  disp = '0;
   logic [15:0] pc_in = '0;
   logic        flag_z = 1'b0;
   logic        flag_c = 1'b0;
   logic [7:0]  reg_b = '0;
   logic        out_valid, invalid, taken, b_we;
   logic [15:0] pc_next;
   logic [7:0]  b_next;
   logic [3:0]  tstates;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] e_pc;
   logic [7:0]  e_b;
   logic        e_we, e_tk, e_inv;
   logic [3:0]  e_ts;

   always #(CLK_PERIOD/2) clk = ~clk;

   rel_branch_seq uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .disp(disp),
      .pc_in(pc_in), .flag_z(flag_z), .flag_c(flag_c), .reg_b(reg_b),
      .out_valid(out_valid), .invalid(invalid), .taken(taken), .pc_next(pc_next),
      .b_next(b_next), .b_we(b_we), .tstates(tstates)
   );

   function automatic logic [15:0] rel_target(logic [15:0] pc, logic [7:0] d);
      int t;
      t = int'(pc) + 1 + int'($signed(d));
      return 16'(t & 16'hFFFF);
   endfunction

   task automatic model(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                        input logic z, input logic c, input logic [7:0] b);
      logic go;
      e_inv = 1'b0; e_we = 1'b0; e_b = b; e_tk = 1'b0; e_ts = 4'd0; e_pc = pc;
      case (op)
         8'h10: begin
            e_we = 1'b1;
            e_b  = 8'((int'(b) + 255) % 256);
            go   = (e_b != 8'd0);
            e_tk = go;
            e_ts = go ? 4'd13 : 4'd8;
            e_pc = go ? rel_target(pc, d) : pc + 16'd1;
         end
         8'h18: begin
            e_tk = 1'b1; e_ts = 4'd12; e_pc = rel_target(pc, d);
         end
         8'h20, 8'h28, 8'h30, 8'h38: begin
            case (op)
               8'h20:   go = !z;
               8'h28:   go = z;
               8'h30:   go = !c;
               default: go = c;
            endcase
            e_tk = go;
            e_ts = go ? 4'd12 : 4'd7;
            e_pc = go ? rel_target(pc, d) : pc + 16'd1;
         end
         default: e_inv = 1'b1;
      endcase
   endtask

   function automatic string tag_of(logic [7:0] op);
      case (op)
         8'h10:                      return "R6/R7";
         8'h18:                      return "R3";
         8'h20, 8'h28, 8'h30, 8'h38: return "R4/R5";
         default:                    return "R9";
      endcase
   endfunction

   task automatic apply(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                        input logic z, input logic c, input logic [7:0] b, input string tag);
      @(negedge clk);
      opcode = op; disp = d; pc_in = pc; flag_z = z; flag_c = c; reg_b = b; in_valid = 1'b1;
      model(op, d, pc, z, c, b);
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b1 || invalid !== e_inv || taken !== e_tk || pc_next !== e_pc ||
          b_next !== e_b || b_we !== e_we || tstates !== e_ts) begin
         n_fail++;
         $display("FAIL %s op=%h: act v=%b inv=%b tk=%b pc=%h b=%h we=%b ts=%0d exp v=1 inv=%b tk=%b pc=%h b=%h we=%b ts=%0d",
                  tag, op, out_valid, invalid, taken, pc_next, b_next, b_we, tstates,
                  e_inv, e_tk, e_pc, e_b, e_we, e_ts);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   localparam logic [7:0] GROUP [6] = '{8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h38};

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      n_checks++;
      if (out_valid !== 1'b0 || invalid !== 1'b0 || taken !== 1'b0 || b_we !== 1'b0 ||
          pc_next !== 16'h0 || b_next !== 8'h0 || tstates !== 4'h0) begin
         n_fail++;
         $display("FAIL R1 reset: act v=%b inv=%b tk=%b we=%b pc=%h b=%h ts=%0d exp all zero",
                  out_valid, invalid, taken, b_we, pc_next, b_next, tstates);
      end
      rst_n = 1'b1;

      // R3 / R8: unconditional jumps with wrap and sign
      apply(8'h18, 8'h80, 16'h0000, 1'b0, 1'b0, 8'h55, "R3/R8 wrap low");
      apply(8'h18, 8'h7F, 16'hFFF0, 1'b1, 1'b1, 8'h55, "R3/R8 wrap high");
      apply(8'h18, 8'hFE, 16'h1234, 1'b0, 1'b1, 8'h00, "R3/R8 self loop");
      // R6 / R7: loop counter edges
      apply(8'h10, 8'hF0, 16'h4000, 1'b0, 1'b0, 8'h01, "R7 exit at one");
      apply(8'h10, 8'hF0, 16'h4000, 1'b1, 1'b1, 8'h00, "R6 wrap from zero");
      apply(8'h10, 8'h05, 16'hFFFF, 1'b0, 1'b0, 8'h02, "R7 taken R8 wrap");
      apply(8'h10, 8'h80, 16'h0010, 1'b1, 1'b0, 8'h01, "R7 exit no wrap");
      // R4 / R5: each condition with flag set and clear
      for (int n = 0; n < 4; n++) begin
         for (int f = 0; f < 2; f++) begin
            apply(8'h20 + 8'(n * 8), 8'h10, 16'h8000, f[0], f[0], 8'h33, "R4/R5 cond");
            apply(8'h20 + 8'(n * 8), 8'hF8, 16'h8000, f[0], !f[0], 8'h33, "R4/R5 cross flag");
         end
      end
      // R9: neighbours of the group
      apply(8'h00, 8'h10, 16'h2222, 1'b1, 1'b1, 8'h01, "R9 op00");
      apply(8'h08, 8'h10, 16'h2222, 1'b0, 1'b0, 8'h00, "R9 op08");
      apply(8'h19, 8'h10, 16'h2222, 1'b0, 1'b0, 8'h01, "R9 op19");
      apply(8'h40, 8'hFF, 16'hFFFF, 1'b1, 1'b0, 8'h80, "R9 op40");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] op;
         if ($urandom_range(9) < 8) op = GROUP[$urandom_range(5)];
         else op = 8'($urandom);
         apply(op, 8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
               ($urandom_range(3) == 0) ? 8'($urandom_range(2)) : 8'($urandom), tag_of(op));
      end

      // R2: strobe falls one cycle after in_valid drops
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R2 out_valid after idle: act %b exp 0", out_valid);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule